// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block derives the bit-rate timing strobe of a serial transmitter or receiver from a fast source clock. The division happens in two stages. An integer prescaler first slows the source clock by a programmable whole ratio. A fractional divider then counts those prescaled cycles against a divisor that has a whole part and a part in sixteenths. Because of the fraction, the average tick period is not tied to a whole number of cycles.

The fraction is reached by dithering. A small phase accumulator adds the sixteenths value once per tick. Whenever it overflows, the following period is one prescaled cycle longer. The average tick rate is therefore source_freq × 16 / ((whole × 16 + sixteenths) × (prescale + 1)).

Software may rewrite the divider fields while the block runs. The block copies the fields into a shadow set only when it is idle or at the edge where a tick is issued, so a period never mixes old and new settings.

Top module: `baud_tick_gen`

## Requirements
- R1: The prescaler divides the source clock by `prescale_sel + 1`: a value of 0 gives no division and 255 divides by 256. With `div_sixteenths` = 0 the spacing between ticks is `div_whole × (prescale_sel + 1)` cycles.
- R2: With a zero fraction every tick period holds exactly `div_whole` prescaled cycles, for any whole value from 1 up to 4095.
- R3: A 4-bit phase accumulator starts at 0 when the block is enabled. At every tick, `div_sixteenths` is added to it. A carry out of bit 3 lengthens the next period by one prescaled cycle (`prescale_sel + 1` source cycles). As a result, exactly `div_sixteenths` of any 16 consecutive periods are lengthened.
- R4: The first tick after `en` rises arrives `div_whole × (prescale_sel + 1)` cycles after the first rising clock edge at which `en` is high.
- R5: While the captured whole value is 0, `baud_tick` stays low. While `en` is high, a nonzero value written to `div_whole` is captured on the next edge, and the first tick then follows `div_whole × (prescale_sel + 1)` edges later.
- R6: While `en` is low, `baud_tick` stays low and the prescaler count, the period count and the phase accumulator are cleared. After a new enable, the sequence starts afresh and no stretch left over from before is applied.
- R7: Changes to the divider fields while the block runs take effect only at a tick edge. The period in progress finishes with the old values. The stretch decision made at that tick also uses the old fraction. A change that is visible exactly at the tick edge applies to the period that starts there.
- R8: `baud_tick` is high for exactly one source cycle whenever the period is longer than one cycle.
- R9: After a synchronous reset, `baud_tick` is low and stays low until the block is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low clears the counting state |
| prescale_sel | input | 8 | Prescaler ratio minus one |
| div_whole | input | 12 | Whole part of the divisor in prescaled cycles; 0 is illegal |
| div_sixteenths | input | 4 | Fractional part of the divisor in sixteenths |
| baud_tick | output | 1 | One-cycle bit-rate strobe |

## Verification
Two things can fall in the same cycle. One is a tick boundary, where the shadow settings are reloaded and the phase accumulator takes its step with the outgoing fraction. The other is a write to the divider ports. The bench provokes this by predicting the edge of an upcoming tick from its reference model and changing the ports on the falling edge just before it. It also makes a separate change in the middle of a period. In both cases the scoreboard compares every measured tick spacing against the model. The model keeps the old settings up to and including that boundary, carries the stretch decision made with the old fraction, and switches to the new whole and prescale values right after it.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

    localparam int PRE_W  = 8;
    localparam int INT_W  = 12;
    localparam int FRAC_W = 4;
    localparam int DIVISOR_W = INT_W + FRAC_W;

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [INT_W-1:0]  whole;
        logic [FRAC_W-1:0] frac;
    } div_cfg_t;

    typedef struct packed {
        logic              carry;
        logic [FRAC_W-1:0] phase;
    } phase_sum_t;

    typedef enum logic [1:0] {
        LD_HOLD     = 2'd0,
        LD_TRACK    = 2'd1,
        LD_BOUNDARY = 2'd2
    } load_mode_t;

    function automatic phase_sum_t phase_add(input logic [FRAC_W-1:0] a,
                                             input logic [FRAC_W-1:0] b);
        phase_sum_t r;
        r = phase_sum_t'({1'b0, a} + {1'b0, b});
        return r;
    endfunction

    function automatic logic [DIVISOR_W-1:0] combined_divisor(input div_cfg_t c);
        return {c.whole, c.frac};
    endfunction

endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
    parameter int W = baud_tick_pkg::PRE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         strobe
);

    logic [W-1:0] cnt;

    always_comb strobe = run && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (strobe) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_PRE_RANGE: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= limit)); // R1

    AST_PRE_GAP: assert property (@(posedge clk) disable iff (rst)
        strobe |=> (!strobe || limit == '0)); // R1

endmodule

// File: rtl/baud_frac_div.sv
module baud_frac_div
    import baud_tick_pkg::*;
#(
    parameter int IW = INT_W,
    parameter int FW = FRAC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          strobe,
    input  logic [IW-1:0] whole,
    input  logic [FW-1:0] frac,
    output logic          boundary,
    output logic          tick
);

    localparam int CNT_W = IW + 1;

    logic [IW-1:0]    dcnt;
    logic [FW-1:0]    phase;
    logic             stretch;
    logic [CNT_W-1:0] last_idx;
    phase_sum_t       step;

    always_comb begin
        last_idx = {1'b0, whole} + CNT_W'(stretch) - CNT_W'(1);
        boundary = run && strobe && ({1'b0, dcnt} == last_idx);
        step     = phase_add(phase, frac);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            dcnt <= '0;
        end else if (boundary) begin
            dcnt <= '0;
        end else if (strobe) begin
            dcnt <= dcnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase   <= '0;
            stretch <= 1'b0;
        end else if (boundary) begin
            phase   <= step.phase;
            stretch <= step.carry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tick <= 1'b0;
        end else begin
            tick <= boundary;
        end
    end

    AST_DCNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        run |-> ({1'b0, dcnt} <= last_idx)); // R2

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !run |=> (phase == '0 && !stretch)); // R6

endmodule

// File: rtl/baud_cfg_hold.sv
module baud_cfg_hold
    import baud_tick_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  div_cfg_t cfg_in,
    input  logic     boundary,
    output div_cfg_t cfg,
    output logic     run
);

    load_mode_t mode;

    always_comb begin
        run = en && (cfg.whole != '0);
        if (!run) begin
            mode = LD_TRACK;
        end else if (boundary) begin
            mode = LD_BOUNDARY;
        end else begin
            mode = LD_HOLD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (mode != LD_HOLD) begin
            cfg <= cfg_in;
        end
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (run && !boundary) |=> $stable(cfg)); // R7

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_tick_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [PRE_W-1:0]  prescale_sel,
    input  logic [INT_W-1:0]  div_whole,
    input  logic [FRAC_W-1:0] div_sixteenths,
    output logic              baud_tick
);

    div_cfg_t cfg_in;
    div_cfg_t cfg;
    logic     run;
    logic     strobe;
    logic     boundary;

    always_comb begin
        cfg_in.pre   = prescale_sel;
        cfg_in.whole = div_whole;
        cfg_in.frac  = div_sixteenths;
    end

    baud_cfg_hold u_cfg (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .cfg_in   (cfg_in),
        .boundary (boundary),
        .cfg      (cfg),
        .run      (run)
    );

    baud_prescaler #(.W(PRE_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .limit  (cfg.pre),
        .strobe (strobe)
    );

    baud_frac_div #(.IW(INT_W), .FW(FRAC_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .strobe   (strobe),
        .whole    (cfg.whole),
        .frac     (cfg.frac),
        .boundary (boundary),
        .tick     (baud_tick)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !en |=> !baud_tick); // R6

    AST_ZERO_WHOLE: assert property (@(posedge clk) disable iff (rst)
        (en && cfg.whole == '0) |=> !baud_tick); // R5

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (baud_tick && (cfg.pre != '0 || cfg.whole > INT_W'(1))) |=> !baud_tick); // R8

endmodule

// File: tb/baud_tick_gen_tb_top.sv
module baud_tick_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [7:0] prescale_sel   = '0;
    logic [11:0] div_whole     = '0;
    logic [3:0] div_sixteenths = '0;
    logic       baud_tick;

    always #4 clk = ~clk;

    baud_tick_gen dut_i (
        .clk            (clk),
        .rst            (rst),
        .en             (en),
        .prescale_sel   (prescale_sel),
        .div_whole      (div_whole),
        .div_sixteenths (div_sixteenths),
        .baud_tick      (baud_tick)
    );

    typedef struct {
        int    val;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   n_vec  = 0;
    int   n_bad  = 0;
    int   m_acc  = 0;
    int   m_st   = 0;
    bit   done   = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int push_period(input int pre, input int whole,
                                       input int frac, input string req);
        int iv;
        int s;
        iv = (whole + m_st) * (pre + 1);
        exp_q.push_back('{iv, req});
        s = m_acc + frac;
        m_st  = (s >= 16) ? 1 : 0;
        m_acc = s % 16;
        return iv;
    endfunction

    task automatic set_cfg(input int pre, input int whole, input int frac);
        prescale_sel   = 8'(pre);
        div_whole      = 12'(whole);
        div_sixteenths = 4'(frac);
    endtask

    task automatic start_run(input int pre, input int whole, input int frac);
        @(negedge clk);
        set_cfg(pre, whole, frac);
        m_acc = 0;
        m_st  = 0;
        @(negedge clk);
        en = 1'b1;
    endtask

    task automatic drain_and_stop();
        while (exp_q.size() != 0) begin
            @(posedge clk);
            #3;
        end
        @(negedge clk);
        en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_tick();
        do begin
            @(posedge clk);
            #2;
        end while (!baud_tick);
    endtask

    // Monitor: measures spacing between ticks and compares with the queue.
    initial begin
        int cnt = 0;
        forever begin
            @(posedge clk);
            #2;
            if (rst || !en) begin
                cnt = 0;
            end else begin
                cnt++;
            end
            if (baud_tick) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 R6 unexpected tick", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (e.val != 0) begin
                        chk(cnt == e.val, e.req, cnt, e.val);
                    end
                end
                cnt = 0;
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int iv;
        int c;

        // R9: reset state
        repeat (3) @(negedge clk);
        chk(baud_tick == 1'b0, "R9 tick during reset", baud_tick, 0);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        chk(baud_tick == 1'b0, "R9 tick after reset", baud_tick, 0);

        // R1 R2 R4 R8: plain integer division, no prescale
        start_run(0, 5, 0);
        void'(push_period(0, 5, 0, "R4 first"));
        for (int i = 0; i < 3; i++) void'(push_period(0, 5, 0, "R2"));
        drain_and_stop();

        // R8: shortest period above one cycle
        start_run(0, 2, 0);
        for (int i = 0; i < 6; i++) void'(push_period(0, 2, 0, "R8"));
        drain_and_stop();

        // R1: prescale by 4
        start_run(3, 4, 0);
        void'(push_period(3, 4, 0, "R4 R1 first"));
        for (int i = 0; i < 3; i++) void'(push_period(3, 4, 0, "R1"));
        drain_and_stop();

        // R1: largest prescale
        start_run(255, 2, 0);
        for (int i = 0; i < 2; i++) void'(push_period(255, 2, 0, "R1 max prescale"));
        drain_and_stop();

        // R2: largest whole value
        start_run(0, 4095, 0);
        for (int i = 0; i < 2; i++) void'(push_period(0, 4095, 0, "R2 max whole"));
        drain_and_stop();

        // R3: fractional dithering, two fractions
        start_run(1, 3, 5);
        for (int i = 0; i < 16; i++) void'(push_period(1, 3, 5, "R3 frac5"));
        drain_and_stop();
        start_run(0, 2, 15);
        for (int i = 0; i < 16; i++) void'(push_period(0, 2, 15, "R3 frac15"));
        drain_and_stop();

        // R7: change in mid period
        start_run(1, 4, 3);
        for (int i = 0; i < 3; i++) void'(push_period(1, 4, 3, "R7 old"));
        wait_tick();
        wait_tick();
        repeat (2) @(negedge clk);
        set_cfg(0, 6, 8);
        for (int i = 0; i < 6; i++) void'(push_period(0, 6, 8, "R7 new"));
        drain_and_stop();

        // R7: change that lands exactly on the tick edge
        start_run(2, 5, 9);
        void'(push_period(2, 5, 9, "R7 edge old"));
        iv = push_period(2, 5, 9, "R7 edge old");
        wait_tick();
        repeat (iv) @(negedge clk);
        set_cfg(1, 2, 7);
        for (int i = 0; i < 6; i++) void'(push_period(1, 2, 7, "R7 edge new"));
        drain_and_stop();

        // R6: disable mid-period clears a pending stretch
        start_run(0, 3, 12);
        for (int i = 0; i < 2; i++) void'(push_period(0, 3, 12, "R6 pre"));
        drain_and_stop();
        chk(baud_tick == 1'b0, "R6 quiet while disabled", baud_tick, 0);
        start_run(0, 3, 12);
        for (int i = 0; i < 3; i++) void'(push_period(0, 3, 12, "R6 fresh"));
        drain_and_stop();

        // R5: zero whole value holds the tick low, then resumes
        @(negedge clk);
        set_cfg(2, 0, 9);
        @(negedge clk);
        en = 1'b1;
        repeat (40) @(negedge clk);
        chk(baud_tick == 1'b0, "R5 zero whole", baud_tick, 0);
        exp_q.push_back('{0, "R5"});
        set_cfg(1, 3, 0);
        c = 0;
        do begin
            @(posedge clk);
            #2;
            c++;
        end while (!baud_tick && c < 100);
        chk(c == 7, "R5 resume", c, 7);
        drain_and_stop();

        finish_run();
    end

endmodule